// File: doc/BRIEF.md
# Prescaled reload timer

This block is an 8-bit down-counting timer with an 8-bit prescaler in front of it. Each of the two stages has a reload register and reloads when it counts past zero. The prescaler's underflow clocks the timer stage, and the timer stage's underflow raises a one-cycle interrupt request. The prescaler input comes either from the system clock through one of four divide enables, or from edges on an external input pin.

Five operating modes share the two counters. Plain timing counts the internal source. Pulse output also toggles an output pin on every timer underflow. Event counting clocks the prescaler with edges of the external input. Width measurement counts the internal source only while the input sits at its active level. Period measurement counts continuously and flags each active edge. A polarity bit picks which level or edge is active. Software controls the block through a small register bus with four addresses. Reads are combinational.

Top module: `pres_timer`

## Requirements
- R1: After reset, all four register addresses read 0, and `irq` and `pulse_out` are low.
- R2: With source select 00 (every clock), prescaler reload P and timer reload T, the timer underflows every (P+1)*(T+1) clocks. `irq` is high for exactly one cycle, the cycle after each underflow.
- R3: Source select (address 3, bits [1:0]) picks the prescaler clock enable: 00 every clock, 01 `en_div8`, 10 `en_div32`, 11 `en_div2`.
- R4: The run bit (control bit 4) at 0 freezes both counters. At 1 they count.
- R5: Writing the prescaler (address 1) or timer (address 2) while stopped loads both the reload register and the counter. Writing while running changes only the reload register, and the counter takes the new value at its next underflow.
- R6: In pulse output mode (control bits [1:0] = 01), `pulse_out` inverts on each timer underflow. In every other mode it holds its level.
- R7: In event mode (control bits [1:0] = 10), the prescaler counts edges of `ext_in`: rising edges when polarity (control bit 3) is 0, falling edges when it is 1.
- R8: In width mode (control bits [1:0] = 11), the counter decrements once per source tick while `ext_in` is at its active level (high for polarity 0, low for polarity 1). The trailing edge sets the edge flag and raises `irq`.
- R9: In period mode (control bits [1:0] = 00 with control bit 2 set), each leading edge (rising for polarity 0) sets the edge flag (control bit 5) and raises `irq`. The opposite edge does neither.
- R10: Each timer underflow sets the underflow flag (control bit 6). Writing 0 to a flag bit clears it, writing 1 leaves it unchanged, and a hardware set in the same cycle wins.
- R11: In plain timer mode (control bits [1:0] = 00, bit 2 clear), edges on `ext_in` neither set the edge flag nor raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_div2 | input | 1 | Clock enable at clk/2 |
| en_div8 | input | 1 | Clock enable at clk/8 |
| en_div32 | input | 1 | Clock enable at clk/32 |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address: 0 control, 1 prescaler, 2 timer, 3 source select |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr` (combinational) |
| ext_in | input | 1 | External input pin (asynchronous) |
| pulse_out | output | 1 | Toggled output pin |
| irq | output | 1 | One-cycle interrupt request |

## Verification
The bound assertions check the following on every clock:
- each stage reloads from its reload register on underflow;
- an underflow is followed by `irq` and a set underflow flag;
- a stopped counter does not move;
- the prescaler moves only on a tick or a write;
- a flag cleared by software stays clear unless hardware sets it;
- `pulse_out` changes only together with an interrupt.

Only the directed scenarios can show the behaviours that depend on whole sequences of events. These are the exact period for given reload values, the effect of each divide enable, the edge and level polarities in the event and measurement modes, the value a width measurement leaves in the counter, and the delayed effect of a reload written while running.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // operating mode field, control bits [1:0]
  localparam logic [1:0] MD_TIMER = 2'b00;
  localparam logic [1:0] MD_PULSE = 2'b01;
  localparam logic [1:0] MD_EVENT = 2'b10;
  localparam logic [1:0] MD_WIDTH = 2'b11;

  // count source select
  localparam logic [1:0] CS_F1  = 2'b00;
  localparam logic [1:0] CS_F8  = 2'b01;
  localparam logic [1:0] CS_F32 = 2'b10;
  localparam logic [1:0] CS_F2  = 2'b11;

  // register addresses
  localparam logic [1:0] RA_CTRL = 2'd0;
  localparam logic [1:0] RA_PRE  = 2'd1;
  localparam logic [1:0] RA_TMR  = 2'd2;
  localparam logic [1:0] RA_CSEL = 2'd3;

  localparam int CTRL_W = 7;

  typedef struct packed {
    logic       unf;   // bit 6 underflow flag
    logic       edg;   // bit 5 edge received flag
    logic       run;   // bit 4 count enable
    logic       pol;   // bit 3 polarity
    logic       per;   // bit 2 period measurement select
    logic [1:0] mode;  // bits 1:0
  } ctrl_t;
endpackage

// File: rtl/pt_sync_edge.sv
module pt_sync_edge #(
  parameter int SYNC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic lvl_on,
  output logic lead,
  output logic trail
);
  logic [SYNC-1:0] sh_q, sh_d;
  logic            prev_q, prev_d;
  logic            cur, rise, fall;

  assign cur = sh_q[SYNC-1];

  always_comb begin
    sh_d   = {sh_q[SYNC-2:0], pin};
    prev_d = cur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      prev_q <= 1'b0;
    end else begin
      sh_q   <= sh_d;
      prev_q <= prev_d;
    end
  end

  // edges come from the raw synchronized level, so a polarity change makes no edge
  always_comb begin
    rise   = cur & ~prev_q;
    fall   = ~cur & prev_q;
    lvl_on = cur ^ pol;
    lead   = pol ? fall : rise;
    trail  = pol ? rise : fall;
  end
endmodule

// File: rtl/pt_src_sel.sv
module pt_src_sel
  import pt_pkg::*;
(
  input  logic [1:0] csel,
  input  logic       en_div2,
  input  logic       en_div8,
  input  logic       en_div32,
  input  logic       is_event,
  input  logic       is_width,
  input  logic       lead,
  input  logic       lvl_on,
  input  logic       run,
  output logic       tick
);
  logic base;
  logic raw;

  always_comb begin
    unique case (csel)
      CS_F1:   base = 1'b1;
      CS_F8:   base = en_div8;
      CS_F32:  base = en_div32;
      default: base = en_div2;
    endcase
    if (is_event)      raw = lead;
    else if (is_width) raw = base & lvl_on;
    else               raw = base;
    tick = run & raw;
  end
endmodule

// File: rtl/pt_stage.sv
module pt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] cnt,
  output logic [W-1:0] rld,
  output logic         unf
);
  logic [W-1:0] cnt_d, rld_d;

  assign unf = tick && (cnt == '0);

  always_comb begin
    cnt_d = cnt;
    rld_d = rld;
    if (tick) cnt_d = (cnt == '0) ? rld : cnt - 1'b1;
    if (wr) begin
      rld_d = wdata;
      if (!run) cnt_d = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      rld <= '0;
    end else begin
      cnt <= cnt_d;
      rld <= rld_d;
    end
  end
endmodule

// File: rtl/pres_timer.sv
module pres_timer
  import pt_pkg::*;
#(
  parameter int DW   = 8,
  parameter int SYNC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_div2,
  input  logic          en_div8,
  input  logic          en_div32,
  input  logic          bus_wr,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          ext_in,
  output logic          pulse_out,
  output logic          irq
);
  // reset: asynchronous assert, synchronous release
  logic [1:0] rs_q;
  logic       rst_i;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_i = rs_q[1];

  ctrl_t      ctrl_q, ctrl_d, wr_c;
  logic [1:0] csel_q, csel_d;
  logic       irq_d, pout_d;
  logic       wr_ctrl, wr_pre, wr_tmr, wr_csel;
  logic       is_event, is_width, is_period, run_on;
  logic       lvl_on, lead, trail, act_edge, edge_set;
  logic       pre_tick, pre_unf, tmr_unf;
  logic [DW-1:0] pre_cnt, pre_rld, tmr_cnt, tmr_rld;
  logic       edg_flag, unf_flag;

  assign wr_ctrl = bus_wr && (bus_addr == RA_CTRL);
  assign wr_pre  = bus_wr && (bus_addr == RA_PRE);
  assign wr_tmr  = bus_wr && (bus_addr == RA_TMR);
  assign wr_csel = bus_wr && (bus_addr == RA_CSEL);
  assign wr_c    = ctrl_t'(bus_wdata[CTRL_W-1:0]);

  assign run_on    = ctrl_q.run;
  assign is_event  = (ctrl_q.mode == MD_EVENT);
  assign is_width  = (ctrl_q.mode == MD_WIDTH);
  assign is_period = (ctrl_q.mode == MD_TIMER) && ctrl_q.per;
  assign edg_flag  = ctrl_q.edg;
  assign unf_flag  = ctrl_q.unf;

  pt_sync_edge #(.SYNC(SYNC)) u_edge (
    .clk(clk), .rst_n(rst_i), .pin(ext_in), .pol(ctrl_q.pol),
    .lvl_on(lvl_on), .lead(lead), .trail(trail)
  );

  pt_src_sel u_src (
    .csel(csel_q), .en_div2(en_div2), .en_div8(en_div8), .en_div32(en_div32),
    .is_event(is_event), .is_width(is_width), .lead(lead), .lvl_on(lvl_on),
    .run(run_on), .tick(pre_tick)
  );

  pt_stage #(.W(DW)) u_pre (
    .clk(clk), .rst_n(rst_i), .tick(pre_tick), .run(run_on), .wr(wr_pre),
    .wdata(bus_wdata), .cnt(pre_cnt), .rld(pre_rld), .unf(pre_unf)
  );

  pt_stage #(.W(DW)) u_tmr (
    .clk(clk), .rst_n(rst_i), .tick(pre_unf), .run(run_on), .wr(wr_tmr),
    .wdata(bus_wdata), .cnt(tmr_cnt), .rld(tmr_rld), .unf(tmr_unf)
  );

  // the measuring modes watch an edge: the trailing edge for width, the leading edge for period
  assign act_edge = is_width ? trail : lead;
  assign edge_set = run_on && (is_width || is_period) && act_edge;

  always_comb begin
    ctrl_d = ctrl_q;
    csel_d = csel_q;
    if (wr_ctrl) begin
      ctrl_d.mode = wr_c.mode;
      ctrl_d.per  = wr_c.per;
      ctrl_d.pol  = wr_c.pol;
      ctrl_d.run  = wr_c.run;
      ctrl_d.edg  = ctrl_q.edg & wr_c.edg;
      ctrl_d.unf  = ctrl_q.unf & wr_c.unf;
    end
    if (edge_set) ctrl_d.edg = 1'b1;
    if (tmr_unf)  ctrl_d.unf = 1'b1;
    if (wr_csel)  csel_d = bus_wdata[1:0];
    irq_d  = tmr_unf | edge_set;
    pout_d = pulse_out ^ (tmr_unf && (ctrl_q.mode == MD_PULSE));
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      ctrl_q    <= '0;
      csel_q    <= CS_F1;
      irq       <= 1'b0;
      pulse_out <= 1'b0;
    end else begin
      ctrl_q    <= ctrl_d;
      csel_q    <= csel_d;
      irq       <= irq_d;
      pulse_out <= pout_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    unique case (bus_addr)
      RA_CTRL: bus_rdata[CTRL_W-1:0] = ctrl_q;
      RA_PRE:  bus_rdata = pre_cnt;
      RA_TMR:  bus_rdata = tmr_cnt;
      default: bus_rdata[1:0] = csel_q;
    endcase
  end
endmodule

// File: rtl/pt_chk.sv
module pt_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          irq,
  input logic          pulse_out,
  input logic          run_on,
  input logic          pre_tick,
  input logic          pre_unf,
  input logic          tmr_unf,
  input logic          wr_pre,
  input logic          wr_tmr,
  input logic          wr_ctrl,
  input logic          wd_edg,
  input logic          edge_set,
  input logic          edg_flag,
  input logic          unf_flag,
  input logic [DW-1:0] pre_cnt,
  input logic [DW-1:0] pre_rld,
  input logic [DW-1:0] tmr_cnt,
  input logic [DW-1:0] tmr_rld
);
  assert_irq_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_unf |=> irq);

  assert_tmr_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_unf |=> (tmr_cnt == $past(tmr_rld)));

  assert_pre_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pre_unf |=> (pre_cnt == $past(pre_rld)));

  assert_stopped_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_on && !wr_tmr) |=> $stable(tmr_cnt));

  assert_pre_moves_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!pre_tick && !wr_pre) |=> $stable(pre_cnt));

  assert_unf_flag_set_R10: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_unf |=> unf_flag);

  assert_edge_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && !wd_edg && !edge_set) |=> !edg_flag);

  assert_toggle_with_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pulse_out) |-> irq);
endmodule

bind pres_timer pt_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_i), .irq(irq), .pulse_out(pulse_out), .run_on(run_on),
  .pre_tick(pre_tick), .pre_unf(pre_unf), .tmr_unf(tmr_unf), .wr_pre(wr_pre),
  .wr_tmr(wr_tmr), .wr_ctrl(wr_ctrl), .wd_edg(bus_wdata[5]), .edge_set(edge_set),
  .edg_flag(edg_flag), .unf_flag(unf_flag), .pre_cnt(pre_cnt), .pre_rld(pre_rld),
  .tmr_cnt(tmr_cnt), .tmr_rld(tmr_rld)
);

// File: tb/sim_pres_timer.sv
`timescale 1ns/1ps
module sim_pres_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en_div2 = 1'b0, en_div8 = 1'b0, en_div32 = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'd0;
  logic [7:0] bus_rdata;
  logic       ext_in = 1'b0;
  logic       pulse_out, irq;

  int n_chk = 0, n_fail = 0, irq_seen = 0, divc = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pres_timer u0 (
    .clk(clk), .rst_n(rst_n), .en_div2(en_div2), .en_div8(en_div8), .en_div32(en_div32),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_in(ext_in), .pulse_out(pulse_out), .irq(irq)
  );

  always @(negedge clk) begin
    divc = divc + 1;
    en_div2  = (divc % 2 == 0);
    en_div8  = (divc % 8 == 0);
    en_div32 = (divc % 32 == 0);
    if (irq) irq_seen = irq_seen + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    #0.5;
    v = int'(bus_rdata);
  endtask

  // control layout: [1:0] mode, [2] period, [3] polarity, [4] run, [5] edge flag, [6] underflow flag
  task automatic wctrl(input logic [1:0] md, input bit per, input bit pol, input bit run,
                       input bit ke, input bit ku);
    wr(2'd0, {1'b0, ku, ke, run, pol, per, md});
  endtask

  task automatic setup(input logic [1:0] cs, input logic [7:0] p, input logic [7:0] t);
    wctrl(2'b00, 0, 0, 0, 0, 0);
    wr(2'd3, {6'd0, cs});
    wr(2'd1, p);
    wr(2'd2, t);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!irq && n < 3000);
  endtask

  task automatic pulse(input int hi, input int lo);
    @(negedge clk); ext_in = 1'b1;
    repeat (hi) @(negedge clk);
    ext_in = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic t_reset;
    int v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v == 0, "R1 register reset", v, 0);
    end
    chk(irq == 0 && pulse_out == 0, "R1 outputs reset", {irq, pulse_out}, 0);
  endtask

  task automatic t_period(input int p, input int t);
    int n;
    setup(2'b00, 8'(p), 8'(t));
    wctrl(2'b00, 0, 0, 1, 0, 0);
    wait_irq(n);
    wait_irq(n);
    chk(n == (p + 1) * (t + 1), "R2 period", n, (p + 1) * (t + 1));
    if (n > 1) begin
      @(negedge clk);
      chk(irq == 0, "R2 irq one cycle", irq, 0);
    end
  endtask

  task automatic t_clksel(input logic [1:0] cs, input int div);
    int n;
    setup(cs, 8'd0, 8'd3);
    wctrl(2'b00, 0, 0, 1, 0, 0);
    wait_irq(n);
    wait_irq(n);
    chk(n == 4 * div, "R3 source select", n, 4 * div);
  endtask

  task automatic t_stop;
    int v1, v2;
    setup(2'b00, 8'd3, 8'd200);
    wctrl(2'b00, 0, 0, 1, 0, 0);
    repeat (20) @(negedge clk);
    wctrl(2'b00, 0, 0, 0, 0, 0);
    rd(2'd2, v1);
    repeat (20) @(negedge clk);
    rd(2'd2, v2);
    chk(v1 < 200, "R4 counts while running", v1, 199);
    chk(v1 == v2, "R4 holds while stopped", v2, v1);
  endtask

  task automatic t_load;
    int v, n;
    setup(2'b00, 8'h21, 8'h5A);
    rd(2'd1, v);
    chk(v == 8'h21, "R5 prescaler load stopped", v, 8'h21);
    rd(2'd2, v);
    chk(v == 8'h5A, "R5 timer load stopped", v, 8'h5A);
    setup(2'b00, 8'd0, 8'd3);
    wctrl(2'b00, 0, 0, 1, 0, 0);
    wait_irq(n);
    wr(2'd2, 8'd7);
    rd(2'd2, v);
    chk(v <= 3, "R5 running write keeps counter", v, 3);
    wait_irq(n);
    wait_irq(n);
    chk(n == 8, "R5 new reload after underflow", n, 8);
  endtask

  task automatic t_pulse;
    int n;
    logic p0;
    setup(2'b00, 8'd0, 8'd4);
    wctrl(2'b01, 0, 0, 1, 0, 0);
    wait_irq(n);
    p0 = pulse_out;
    wait_irq(n);
    chk(pulse_out == ~p0, "R6 toggle on underflow", pulse_out, ~p0);
    wctrl(2'b00, 0, 0, 1, 0, 0);
    p0 = pulse_out;
    wait_irq(n);
    wait_irq(n);
    chk(pulse_out == p0, "R6 hold in timer mode", pulse_out, p0);
  endtask

  task automatic t_event;
    int v;
    setup(2'b00, 8'd0, 8'd5);
    wctrl(2'b10, 0, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    pulse(4, 4);
    pulse(4, 4);
    rd(2'd2, v);
    chk(v == 3, "R7 rising edges counted", v, 3);
    wctrl(2'b10, 0, 1, 1, 0, 0);
    @(negedge clk); ext_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd2, v);
    chk(v == 3, "R7 rising ignored with polarity 1", v, 3);
    ext_in = 1'b0;
    repeat (5) @(negedge clk);
    rd(2'd2, v);
    chk(v == 2, "R7 falling counted with polarity 1", v, 2);
  endtask

  task automatic t_width;
    int v, s;
    setup(2'b00, 8'd0, 8'd200);
    wctrl(2'b11, 0, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    s = irq_seen;
    pulse(10, 6);
    rd(2'd2, v);
    chk(v >= 189 && v <= 191, "R8 width count", v, 190);
    rd(2'd0, v);
    chk(v[5] == 1, "R8 edge flag on trailing edge", v[5], 1);
    chk(irq_seen == s + 1, "R8 irq on trailing edge", irq_seen - s, 1);
  endtask

  task automatic t_permeas;
    int v, s;
    setup(2'b00, 8'd0, 8'd200);
    wctrl(2'b00, 1, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    s = irq_seen;
    @(negedge clk); ext_in = 1'b1;
    repeat (5) @(negedge clk);
    rd(2'd0, v);
    chk(v[5] == 1, "R9 leading edge sets flag", v[5], 1);
    chk(irq_seen == s + 1, "R9 irq on leading edge", irq_seen - s, 1);
    ext_in = 1'b0;
    repeat (5) @(negedge clk);
    chk(irq_seen == s + 1, "R9 trailing edge no irq", irq_seen - s, 1);
    // flag write semantics
    wctrl(2'b00, 1, 0, 1, 1, 0);
    rd(2'd0, v);
    chk(v[5] == 1, "R10 write 1 keeps edge flag", v[5], 1);
    wctrl(2'b00, 1, 0, 1, 0, 0);
    rd(2'd0, v);
    chk(v[5] == 0, "R10 write 0 clears edge flag", v[5], 0);
  endtask

  task automatic t_unf_flag;
    int v;
    setup(2'b00, 8'd0, 8'd0);
    wctrl(2'b00, 0, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    wctrl(2'b00, 0, 0, 0, 0, 1);
    rd(2'd0, v);
    chk(v[6] == 1, "R10 underflow flag set and kept", v[6], 1);
    wctrl(2'b00, 0, 0, 0, 0, 0);
    rd(2'd0, v);
    chk(v[6] == 0, "R10 underflow flag cleared", v[6], 0);
  endtask

  task automatic t_ignore;
    int v, s;
    setup(2'b00, 8'd0, 8'd200);
    wctrl(2'b00, 0, 0, 1, 0, 0);
    repeat (4) @(negedge clk);
    s = irq_seen;
    pulse(5, 5);
    pulse(5, 5);
    rd(2'd0, v);
    chk(v[5] == 0, "R11 timer mode ignores edges (flag)", v[5], 0);
    chk(irq_seen == s, "R11 timer mode ignores edges (irq)", irq_seen - s, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    t_period(1, 3);
    t_period(0, 0);
    t_period(2, 1);
    t_clksel(2'b01, 8);
    t_clksel(2'b10, 32);
    t_clksel(2'b11, 2);
    t_stop;
    t_load;
    t_pulse;
    t_event;
    t_width;
    t_permeas;
    t_unf_flag;
    t_ignore;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule